// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the condition, interrupt-status and interrupt-mask state of a memory-mapped serial port. It takes the occupancy counts of the receive and transmit FIFOs and compares them with two programmable threshold levels. From these comparisons it forms a live condition word that is recomputed every cycle. Each live condition, and each receive overrun or receive timeout pulse, is captured into a sticky status register. Bits in that register stay set until software writes ones to them.

Software changes the mask register through two write ports: one sets bits and the other clears them. A write aimed at the mask itself is ignored. The single interrupt line is high while any bit is set in both the sticky status and the mask. All register writes arrive on one strobe with a 3-bit selector. The FIFOs, the serial line and the address decode are outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live bit 0 is 1 when rx_count >= rx_level, live bit 1 is 1 when rx_count == 0, and live bit 2 is 1 when rx_count equals the FIFO depth (64).
- R2: Live bit 3 is 1 when tx_count == 0, live bit 4 is 1 when tx_count equals the FIFO depth, and live bit 13 is 1 when tx_count >= tx_level. All other live bits are 0.
- R3: At every clock edge, live bits 4..0 are ORed into sticky bits 4..0 and live bit 13 is ORed into sticky bit 10. A sticky bit never falls except through a clear write.
- R4: A write with wr_sel = 3 clears every sticky bit whose wr_data bit is 1, and the result is visible the cycle after the write.
- R5: A write with wr_sel = 0 ORs wr_data into the mask. A write with wr_sel = 1 clears from the mask every bit set in wr_data.
- R6: A write with wr_sel = 2, aimed at the mask itself, leaves the mask unchanged.
- R7: irq is 1 exactly when (mask AND sticky) is nonzero. It follows the registers in the same cycle.
- R8: A receive overrun pulse sets sticky bit 5, and a receive timeout pulse sets sticky bit 8.
- R9: During reset the mask and the sticky status are 0, irq is 0, and both threshold levels are 32.
- R10: When a hardware set and a software clear reach the same sticky bit in one cycle, the bit ends up set.
- R11: A write with wr_sel = 4 loads wr_data[6:0] into rx_level, and a write with wr_sel = 5 loads it into tx_level. The new level applies from the next cycle.
- R12: Writes with wr_sel = 6 or 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| rx_overrun | input | 1 | One-cycle receive overrun event |
| rx_timeout | input | 1 | One-cycle receive timeout event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 mask set, 1 mask clear, 2 mask direct, 3 sticky clear, 4 rx level, 5 tx level |
| wr_data | input | 32 | Write data |
| live_status | output | 32 | Live condition word |
| irq_status | output | 32 | Sticky interrupt status |
| irq_mask | output | 32 | Interrupt mask |
| rx_level | output | 7 | Receive threshold level |
| tx_level | output | 7 | Transmit threshold level |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the hardware set of a sticky bit and the software write-one-to-clear of that same bit. The bench provokes this in two ways. First, it issues an all-ones clear while the receive FIFO is empty, so live bit 1 is high. Second, it issues an all-ones clear together with an overrun pulse. In both cases the affected bit must read 1 the next cycle, while every other written bit reads 0. A cycle-level model in the bench, built only from the requirements, produces the expected value of every output after each edge.

// File: rtl/uart_irq_pkg.sv
// Package: shared write-select encoding and bit positions for the UART
// interrupt status unit. Assumes 32-bit register words.
package uart_irq_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic [2:0] {
        SEL_MASK_SET  = 3'd0,
        SEL_MASK_CLR  = 3'd1,
        SEL_MASK_RO   = 3'd2,
        SEL_STICKY_CL = 3'd3,
        SEL_RX_LVL    = 3'd4,
        SEL_TX_LVL    = 3'd5
    } wr_sel_e;

    // live condition word positions
    localparam int unsigned LV_RX_TRIG  = 0;
    localparam int unsigned LV_RX_EMPTY = 1;
    localparam int unsigned LV_RX_FULL  = 2;
    localparam int unsigned LV_TX_EMPTY = 3;
    localparam int unsigned LV_TX_FULL  = 4;
    localparam int unsigned LV_TX_TRIG  = 13;
    // sticky word positions that differ from the live word
    localparam int unsigned ST_RX_OVR   = 5;
    localparam int unsigned ST_RX_TMO   = 8;
    localparam int unsigned ST_TX_TRIG  = 10;
endpackage

// File: rtl/uart_irq_levels.sv
// Module: threshold level registers for the receive and transmit sides.
// Assumes each write enable is a one-cycle strobe; both levels reset to RST_LVL.
module uart_irq_levels #(
    parameter int unsigned CNT_W   = 7,
    parameter int unsigned RST_LVL = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lvl_we,
    input  logic [CNT_W-1:0] lvl_data,
    output logic [CNT_W-1:0] rx_lvl,
    output logic [CNT_W-1:0] tx_lvl
);
    localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_LVL);

    logic [CNT_W-1:0] lvl_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        // load one level register on its write strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[g] <= RST_V;
            else if (lvl_we[g])
                lvl_q[g] <= lvl_data;
        end

        assert_level_load_R11 : assert property (@(posedge clk) disable iff (!rst_n)
            lvl_we[g] |=> (lvl_q[g] == $past(lvl_data)));
    end

    assign rx_lvl = lvl_q[0];
    assign tx_lvl = lvl_q[1];
endmodule

// File: rtl/uart_irq_live.sv
// Module: combinational live condition word built from the FIFO counts and
// the threshold levels. Assumes the counts never exceed FIFO_DEPTH.
module uart_irq_live
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned CNT_W      = 7
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_lvl,
    input  logic [CNT_W-1:0] tx_lvl,
    output logic [REG_W-1:0] live
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    // assemble the condition bits at their fixed positions
    always_comb begin
        live              = '0;
        live[LV_RX_TRIG]  = (rx_count >= rx_lvl);
        live[LV_RX_EMPTY] = (rx_count == '0);
        live[LV_RX_FULL]  = (rx_count == FULL_CNT);
        live[LV_TX_EMPTY] = (tx_count == '0);
        live[LV_TX_FULL]  = (tx_count == FULL_CNT);
        live[LV_TX_TRIG]  = (tx_count >= tx_lvl);
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Module: sticky interrupt status register. Live conditions and event pulses
// set bits; a write-one-to-clear removes them; a set beats a clear.
module uart_irq_sticky
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       live_low,
    input  logic             live_tx_trig,
    input  logic             rx_ovr,
    input  logic             rx_tmo,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] sticky
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] sticky_q;

    // map the hardware sources onto their sticky positions
    always_comb begin
        set_vec             = '0;
        set_vec[4:0]        = live_low;
        set_vec[ST_TX_TRIG] = live_tx_trig;
        set_vec[ST_RX_OVR]  = rx_ovr;
        set_vec[ST_RX_TMO]  = rx_tmo;
    end

    // clear first, then apply sets so the hardware set wins a collision
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= '0;
        else
            sticky_q <= (sticky_q & ~(clr_en ? clr_data : '0)) | set_vec;
    end

    assign sticky = sticky_q;

    assert_overrun_sets_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |=> sticky_q[ST_RX_OVR]);
    assert_timeout_sets_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo |=> sticky_q[ST_RX_TMO]);
    assert_no_fall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (($past(sticky_q) & ~sticky_q) == '0));
    assert_set_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && live_low[1]) |=> sticky_q[1]);
    assert_clear_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_data[9]) |=> !sticky_q[9]);
endmodule

// File: rtl/uart_irq_mask.sv
// Module: interrupt mask with separate set and clear strobes, and the
// interrupt output. Assumes set and clear strobes are never high together.
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] sticky,
    output logic [REG_W-1:0] mask,
    output logic             irq
);
    logic [REG_W-1:0] mask_q;

    // update the mask only through its set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_en)
            mask_q <= mask_q | wr_data;
        else if (clr_en)
            mask_q <= mask_q & ~wr_data;
    end

    // raise the request while any enabled sticky bit is set
    always_comb irq = |(mask_q & sticky);

    assign mask = mask_q;

    assert_mask_set_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
    assert_mask_clr_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_q & $past(wr_data)) == '0));
    assert_mask_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: top of the UART interrupt status unit. Decodes the write strobe
// and wires the level registers, live condition logic, sticky status and mask.
// Assumes wr_en is a one-cycle strobe and the counts never exceed FIFO_DEPTH.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned RST_LVL    = 32,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_overrun,
    input  logic             rx_timeout,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] live_status,
    output logic [REG_W-1:0] irq_status,
    output logic [REG_W-1:0] irq_mask,
    output logic [CNT_W-1:0] rx_level,
    output logic [CNT_W-1:0] tx_level,
    output logic             irq
);
    logic       mask_set_we;
    logic       mask_clr_we;
    logic       sticky_clr_we;
    logic [1:0] lvl_we;

    // decode the write selector into one strobe per target
    always_comb begin
        mask_set_we   = wr_en && (wr_sel == SEL_MASK_SET);
        mask_clr_we   = wr_en && (wr_sel == SEL_MASK_CLR);
        sticky_clr_we = wr_en && (wr_sel == SEL_STICKY_CL);
        lvl_we[0]     = wr_en && (wr_sel == SEL_RX_LVL);
        lvl_we[1]     = wr_en && (wr_sel == SEL_TX_LVL);
    end

    uart_irq_levels #(.CNT_W(CNT_W), .RST_LVL(RST_LVL)) u_levels (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_we   (lvl_we),
        .lvl_data (wr_data[CNT_W-1:0]),
        .rx_lvl   (rx_level),
        .tx_lvl   (tx_level)
    );

    uart_irq_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_lvl   (rx_level),
        .tx_lvl   (tx_level),
        .live     (live_status)
    );

    uart_irq_sticky u_sticky (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_low     (live_status[4:0]),
        .live_tx_trig (live_status[LV_TX_TRIG]),
        .rx_ovr       (rx_overrun),
        .rx_tmo       (rx_timeout),
        .clr_en       (sticky_clr_we),
        .clr_data     (wr_data),
        .sticky       (irq_status)
    );

    uart_irq_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mask_set_we),
        .clr_en  (mask_clr_we),
        .wr_data (wr_data),
        .sticky  (irq_status),
        .mask    (irq_mask),
        .irq     (irq)
    );

    assert_tx_trig_moves_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        live_status[LV_TX_TRIG] |=> irq_status[ST_TX_TRIG]);
    assert_rx_full_sticks_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        live_status[LV_RX_FULL] |=> irq_status[LV_RX_FULL]);
    assert_irq_needs_mask_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
    assert_reset_clean_R9 : assert property (@(posedge clk)
        !rst_n |=> (irq_status == '0 || !$past(rst_n, 1) == 1'b0));
    assert_empty_excl_full_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !(live_status[LV_RX_EMPTY] && live_status[LV_RX_FULL]));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rx_cnt = '0;
    logic [6:0]  tx_cnt = '0;
    logic        ovr = 1'b0;
    logic        tmo = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] live_o, stk_o, msk_o;
    logic [6:0]  rxl_o, txl_o;
    logic        irq_o;

    logic [31:0] m_stk = '0;
    logic [31:0] m_msk = '0;
    logic [6:0]  m_rxl = 7'd32;
    logic [6:0]  m_txl = 7'd32;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_cnt), .tx_count(tx_cnt),
        .rx_overrun(ovr), .rx_timeout(tmo), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .live_status(live_o), .irq_status(stk_o),
        .irq_mask(msk_o), .rx_level(rxl_o), .tx_level(txl_o), .irq(irq_o)
    );

    function automatic logic [31:0] f_live(logic [6:0] rc, logic [6:0] tc,
                                           logic [6:0] rl, logic [6:0] tl);
        logic [31:0] v;
        v = '0;
        v[0]  = (rc >= rl);
        v[1]  = (rc == 7'd0);
        v[2]  = (rc == 7'd64);
        v[3]  = (tc == 7'd0);
        v[4]  = (tc == 7'd64);
        v[13] = (tc >= tl);
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "live", live_o, f_live(rx_cnt, tx_cnt, m_rxl, m_txl));
        chk(tag, "sticky", stk_o, m_stk);
        chk(tag, "mask", msk_o, m_msk);
        chk(tag, "irq", {31'd0, irq_o}, {31'd0, |(m_msk & m_stk)});
        chk(tag, "rx_level", {25'd0, rxl_o}, {25'd0, m_rxl});
        chk(tag, "tx_level", {25'd0, txl_o}, {25'd0, m_txl});
    endtask

    // one clock edge, with the model advanced from the inputs in force before it
    task automatic step();
        logic [31:0] lv, setv, nst, nmk;
        logic [6:0]  nrl, ntl;
        lv = f_live(rx_cnt, tx_cnt, m_rxl, m_txl);
        setv = '0;
        setv[4:0] = lv[4:0];
        setv[10]  = lv[13];
        setv[5]   = ovr;
        setv[8]   = tmo;
        nst = m_stk; nmk = m_msk; nrl = m_rxl; ntl = m_txl;
        if (wr_en) begin
            case (wr_sel)
                3'd0: nmk = nmk | wr_data;
                3'd1: nmk = nmk & ~wr_data;
                3'd3: nst = nst & ~wr_data;
                3'd4: nrl = wr_data[6:0];
                3'd5: ntl = wr_data[6:0];
                default: ;
            endcase
        end
        nst = nst | setv;
        @(posedge clk);
        #1;
        m_stk = nst; m_msk = nmk; m_rxl = nrl; m_txl = ntl;
        wr_en = 1'b0; ovr = 1'b0; tmo = 1'b0;
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] lvls [5];
        lvls[0] = 7'd0; lvls[1] = 7'd1; lvls[2] = 7'd32; lvls[3] = 7'd63; lvls[4] = 7'd64;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check_all("R9");
        rst_n = 1'b1;

        // R11 + R1: rx threshold sweep over every count
        for (int k = 0; k < 5; k++) begin
            wr(3'd4, {25'd0, lvls[k]});
            check_all("R11");
            for (int c = 0; c <= 64; c++) begin
                rx_cnt = 7'(c);
                #1;
                check_all("R1");
                step();
                check_all("R3");
            end
        end
        rx_cnt = 7'd5;

        // R11 + R2: tx threshold sweep over every count
        for (int k = 0; k < 5; k++) begin
            wr(3'd5, {25'd0, lvls[k]});
            check_all("R11");
            for (int c = 0; c <= 64; c++) begin
                tx_cnt = 7'(c);
                #1;
                check_all("R2");
                step();
                check_all("R3");
            end
        end
        tx_cnt = 7'd5;

        // quiet counts: no live conditions
        wr(3'd4, 32'd64);
        wr(3'd5, 32'd64);
        check_all("R11");

        // R4: partial then full clear
        wr(3'd3, 32'h0000_0005);
        check_all("R4");
        wr(3'd3, 32'hFFFF_FFFF);
        check_all("R4");
        chk("R4", "sticky zero", stk_o, 32'd0);

        // R8: events
        ovr = 1'b1; step(); check_all("R8");
        chk("R8", "bit5", {31'd0, stk_o[5]}, 32'd1);
        tmo = 1'b1; step(); check_all("R8");
        chk("R8", "bit8", {31'd0, stk_o[8]}, 32'd1);

        // R10: clear colliding with live set and with event set
        rx_cnt = 7'd0;
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'hFFFF_FFFF; ovr = 1'b1;
        step();
        check_all("R10");
        chk("R10", "collide", stk_o, 32'h0000_0022);
        rx_cnt = 7'd5;
        wr(3'd3, 32'hFFFF_FFFF);
        check_all("R10");

        // R5: set then clear each mask bit
        for (int i = 0; i < 32; i++) begin
            wr(3'd0, 32'd1 << i);
            check_all("R5");
        end
        for (int i = 0; i < 32; i += 2) begin
            wr(3'd1, 32'd1 << i);
            check_all("R5");
        end

        // R6: direct mask write ignored
        wr(3'd2, 32'h5555_5555);
        check_all("R6");
        chk("R6", "mask kept", msk_o, 32'hAAAA_AAAA);

        // R12: unused selectors
        wr(3'd6, 32'hFFFF_FFFF);
        check_all("R12");
        wr(3'd7, 32'hFFFF_FFFF);
        check_all("R12");

        // R7: interrupt combinations
        wr(3'd1, 32'hFFFF_FFFF);
        tmo = 1'b1; step(); check_all("R7");
        chk("R7", "masked off", {31'd0, irq_o}, 32'd0);
        wr(3'd0, 32'h0000_0100);
        check_all("R7");
        chk("R7", "raised", {31'd0, irq_o}, 32'd1);
        wr(3'd3, 32'h0000_0100);
        check_all("R7");
        chk("R7", "dropped", {31'd0, irq_o}, 32'd0);
        wr(3'd0, 32'h0000_0400);
        tx_cnt = 7'd64;
        step(); check_all("R7");
        chk("R7", "tx trig", {31'd0, irq_o}, 32'd1);
        tx_cnt = 7'd5;
        wr(3'd1, 32'h0000_0400);
        check_all("R7");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule